// File: doc/BRIEF.md
# SDLC Loop Repeater Controller

This block sets where a node sits on an SDLC loop. It handles one serial bit for each bit-clock enable. The block passes the incoming line to the outgoing line and moves through three phases: joining the loop, sending on it, and leaving it. When the node is not inserted, the outgoing bit is a combinational copy of the incoming bit. When the node is inserted, one register adds a single bit-time of delay. That register is also the point where an end-of-poll (a 0 followed by seven 1s) is rewritten into an opening flag. The local framer's bits then take over from the repeated stream until that framer marks its last bit.

Software-side control is modelled as two level inputs. `loop_en` asks for loop operation, and `go_active` allows the node to join and to transmit. Four registered status bits report progress: inserted, sending, hunting for a flag, and a run of seven 1s seen. Zero insertion, CRC and framing are handled elsewhere.

Top module: `loop_repeater`

## Requirements
- R1: While `rst` is high at a clock edge, all four status outputs become 0 after that edge, and `line_tx` is a combinational copy of `line_rx` (no delay inserted).
- R2: With `loop_en` high and `go_active` low, no status output changes and `line_tx` stays a combinational copy of `line_rx`.
- R3: The run counter of received 1s advances only on `bit_en` and clears on a received 0. Insertion needs seven consecutive 1s, all received after `go_active` was raised.
- R4: On the seventh consecutive 1 after `go_active`, `on_loop`, `hunt` and `brk_abort` go to 1. From then on, `line_tx` shows the bit received at the previous `bit_en`.
- R5: `brk_abort` clears on the next received 0. `hunt` clears when a flag 01111110 is received, which is a 0, then six 1s, then a 0.
- R6: After `hunt` clears, the next end-of-poll (a 0 then seven 1s) makes the node ready to send. It does not start transmission, and the end-of-poll is repeated unchanged.
- R7: When the node is ready and `go_active` is high, the next end-of-poll has its seventh 1 sent as 0, so the output forms a flag. `loop_sending`, `brk_abort` and `hunt` go to 1 on that bit. If `go_active` is low, the end-of-poll is repeated unchanged and `loop_sending` stays 0.
- R8: While `loop_sending` is 1, `line_tx` shows the `local_tx` bit sampled at the previous `bit_en`, and `line_rx` has no effect on it. Clearing `go_active` does not stop the frame.
- R9: The bit that carries `local_last` is the final local bit. `loop_sending` clears on it, and from the next `bit_en` on `line_tx` again shows `line_rx` delayed by one bit.
- R10: When `loop_en` is cleared while the node is inserted and not sending, the node stays inserted until seven further consecutive 1s arrive. It then clears `on_loop`, sets `brk_abort` and `hunt`, and returns to combinational pass-through.
- R11: A drop of `loop_en` during a local frame is deferred. The node stays inserted until seven consecutive 1s arrive after that frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe per line bit time |
| line_rx | input | 1 | Received line bit |
| local_tx | input | 1 | Bit from the local framer, sampled while sending |
| local_last | input | 1 | High with the framer's final bit |
| loop_en | input | 1 | Request loop operation |
| go_active | input | 1 | Permission to join and to transmit |
| line_tx | output | 1 | Outgoing line bit |
| on_loop | output | 1 | Node inserted with one-bit delay |
| loop_sending | output | 1 | Local frame replaces repeated stream |
| hunt | output | 1 | Waiting for a received flag |
| brk_abort | output | 1 | Seven-ones event seen, cleared by a 0 |

## Verification
The assertions assume that `bit_en` is a single-cycle strobe and that `loop_en` stays low once a leave has started. They also assume that `go_active` and `loop_en` change only in cycles without `bit_en`. The stimulus meets these assumptions. It changes control levels at falling clock edges between bit strobes, and it pulses `bit_en` for exactly one cycle in every four. Each bit pattern is built so that the seventh 1 falls on a known strobe, which makes every join, conversion and drop land on a predictable bit.

// File: rtl/loop_rep_pkg.sv
package loop_rep_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_ARMED,
    ST_SEEK,
    ST_HUNT,
    ST_WAIT_EOP,
    ST_READY,
    ST_SEND,
    ST_LEAVE
  } loop_state_t;

  function automatic logic inserted(input loop_state_t s);
    return (s == ST_HUNT) || (s == ST_WAIT_EOP) || (s == ST_READY) ||
           (s == ST_SEND) || (s == ST_LEAVE);
  endfunction

endpackage

// File: rtl/ones_run_tracker.sv
module ones_run_tracker #(
  parameter int RUN_LEN = 7,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx,
  input  logic clr,
  output logic run_done,
  output logic flag_hit,
  output logic eop_hit
);

  localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] EDGE_VAL = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] ones_q;
  logic             after_zero_q;
  logic             at_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q       <= '0;
      after_zero_q <= 1'b0;
    end else if (clr) begin
      ones_q       <= '0;
      after_zero_q <= 1'b0;
    end else if (bit_en) begin
      if (rx) begin
        if (ones_q != SAT_VAL) ones_q <= ones_q + 1'b1;
      end else begin
        ones_q       <= '0;
        after_zero_q <= 1'b1;
      end
    end
  end

  // six 1s held, current bit decides: 1 completes a run, 0 closes a flag
  assign at_edge  = bit_en && (ones_q == EDGE_VAL);
  assign run_done = at_edge && rx;
  assign eop_hit  = at_edge && rx && after_zero_q;
  assign flag_hit = at_edge && !rx && after_zero_q;

endmodule

// File: rtl/loop_ctrl_fsm.sv
module loop_ctrl_fsm
  import loop_rep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx,
  input  logic loop_en,
  input  logic go_active,
  input  logic local_last,
  input  logic run_done,
  input  logic flag_hit,
  input  logic eop_hit,
  output logic cnt_clr,
  output logic convert,
  output logic on_loop,
  output logic loop_sending,
  output logic hunt,
  output logic brk_abort
);

  loop_state_t state_q, state_n;
  logic        mark_ev;
  logic        hunt_n, brk_n;

  always_comb begin
    state_n = state_q;
    cnt_clr = 1'b0;
    mark_ev = 1'b0;
    convert = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (loop_en) state_n = ST_ARMED;
      end
      ST_ARMED: begin
        if (!loop_en) state_n = ST_OFF;
        else if (go_active) begin
          state_n = ST_SEEK;
          cnt_clr = 1'b1;
        end
      end
      ST_SEEK: begin
        if (!loop_en) state_n = ST_OFF;
        else if (!go_active) state_n = ST_ARMED;
        else if (run_done) begin
          state_n = ST_HUNT;
          mark_ev = 1'b1;
        end
      end
      ST_HUNT: begin
        if (!loop_en) begin
          state_n = ST_LEAVE;
          cnt_clr = 1'b1;
        end else if (flag_hit) state_n = ST_WAIT_EOP;
      end
      ST_WAIT_EOP: begin
        if (!loop_en) begin
          state_n = ST_LEAVE;
          cnt_clr = 1'b1;
        end else if (eop_hit) state_n = ST_READY;
      end
      ST_READY: begin
        if (!loop_en) begin
          state_n = ST_LEAVE;
          cnt_clr = 1'b1;
        end else if (go_active && eop_hit) begin
          state_n = ST_SEND;
          mark_ev = 1'b1;
          convert = 1'b1;
        end
      end
      ST_SEND: begin
        if (bit_en && local_last) begin
          if (loop_en) state_n = ST_READY;
          else begin
            state_n = ST_LEAVE;
            cnt_clr = 1'b1;
          end
        end
      end
      ST_LEAVE: begin
        if (run_done) begin
          state_n = ST_OFF;
          mark_ev = 1'b1;
        end
      end
      default: state_n = ST_OFF;
    endcase
  end

  always_comb begin
    brk_n = brk_abort;
    if (bit_en && !rx) brk_n = 1'b0;
    if (mark_ev)       brk_n = 1'b1;
    hunt_n = hunt;
    if (flag_hit)      hunt_n = 1'b0;
    if (mark_ev)       hunt_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_OFF;
      on_loop      <= 1'b0;
      loop_sending <= 1'b0;
      hunt         <= 1'b0;
      brk_abort    <= 1'b0;
    end else begin
      state_q      <= state_n;
      on_loop      <= inserted(state_n);
      loop_sending <= (state_n == ST_SEND);
      hunt         <= hunt_n;
      brk_abort    <= brk_n;
    end
  end

endmodule

// File: rtl/line_delay_path.sv
module line_delay_path (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_rx,
  input  logic local_tx,
  input  logic sending,
  input  logic convert,
  input  logic insert,
  output logic line_tx
);

  logic stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= 1'b0;
    else if (bit_en) begin
      if (sending)      stage_q <= local_tx;
      else if (convert) stage_q <= 1'b0;
      else              stage_q <= line_rx;
    end
  end

  // bypass keeps the uninserted path free of any register
  assign line_tx = insert ? stage_q : line_rx;

endmodule

// File: rtl/loop_repeater.sv
module loop_repeater #(
  parameter int RUN_LEN = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_rx,
  input  logic local_tx,
  input  logic local_last,
  input  logic loop_en,
  input  logic go_active,
  output logic line_tx,
  output logic on_loop,
  output logic loop_sending,
  output logic hunt,
  output logic brk_abort
);

  logic run_done, flag_hit, eop_hit;
  logic cnt_clr, convert;

  ones_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .rx       (line_rx),
    .clr      (cnt_clr),
    .run_done (run_done),
    .flag_hit (flag_hit),
    .eop_hit  (eop_hit)
  );

  loop_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .bit_en       (bit_en),
    .rx           (line_rx),
    .loop_en      (loop_en),
    .go_active    (go_active),
    .local_last   (local_last),
    .run_done     (run_done),
    .flag_hit     (flag_hit),
    .eop_hit      (eop_hit),
    .cnt_clr      (cnt_clr),
    .convert      (convert),
    .on_loop      (on_loop),
    .loop_sending (loop_sending),
    .hunt         (hunt),
    .brk_abort    (brk_abort)
  );

  line_delay_path u_path (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .line_rx  (line_rx),
    .local_tx (local_tx),
    .sending  (loop_sending),
    .convert  (convert),
    .insert   (on_loop),
    .line_tx  (line_tx)
  );

endmodule

// File: rtl/loop_repeater_checker.sv
module loop_repeater_checker (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic line_rx,
  input logic loop_en,
  input logic go_active,
  input logic line_tx,
  input logic on_loop,
  input logic loop_sending,
  input logic hunt,
  input logic brk_abort
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!on_loop && !loop_sending && !hunt && !brk_abort));

  p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
    !on_loop |-> (line_tx == line_rx));

  p_bit_paced_r3: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(on_loop) && $stable(loop_sending)));

  p_join_marks_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(on_loop) |-> (brk_abort && hunt && $past(go_active) && $past(bit_en)));

  p_send_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(loop_sending) |-> (brk_abort && hunt));

  p_send_inside_r8: assert property (@(posedge clk) disable iff (rst)
    loop_sending |-> on_loop);

  p_drop_marks_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(on_loop) |-> (brk_abort && hunt && !$past(loop_sending)));

endmodule

bind loop_repeater loop_repeater_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_en       (bit_en),
  .line_rx      (line_rx),
  .loop_en      (loop_en),
  .go_active    (go_active),
  .line_tx      (line_tx),
  .on_loop      (on_loop),
  .loop_sending (loop_sending),
  .hunt         (hunt),
  .brk_abort    (brk_abort)
);

// File: tb/loop_repeater_test.sv
`timescale 1ns/1ps
module loop_repeater_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, line_rx = 1'b0, local_tx = 1'b0, local_last = 1'b0;
  logic loop_en = 1'b0, go_active = 1'b0;
  logic line_tx, on_loop, loop_sending, hunt, brk_abort;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  loop_repeater uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_rx(line_rx),
    .local_tx(local_tx), .local_last(local_last), .loop_en(loop_en),
    .go_active(go_active), .line_tx(line_tx), .on_loop(on_loop),
    .loop_sending(loop_sending), .hunt(hunt), .brk_abort(brk_abort)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic put(input logic rx, input logic ltx, input logic last);
    @(negedge clk);
    line_rx = rx; local_tx = ltx; local_last = last; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; local_last = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic put_ones(input int n);
    for (int i = 0; i < n; i++) put(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "on_loop", on_loop, 1'b0);
    chk("R1", "loop_sending", loop_sending, 1'b0);
    chk("R1", "hunt", hunt, 1'b0);
    chk("R1", "brk_abort", brk_abort, 1'b0);
    line_rx = 1'b1; #1 chk("R1", "bypass high", line_tx, 1'b1);
    line_rx = 1'b0; #1 chk("R1", "bypass low", line_tx, 1'b0);
  endtask

  task automatic t_armed;
    @(negedge clk) loop_en = 1'b1;
    put_ones(8);
    put(1'b0, 1'b0, 1'b0);
    chk("R2", "on_loop no go", on_loop, 1'b0);
    chk("R2", "brk no go", brk_abort, 1'b0);
    @(negedge clk) line_rx = 1'b1; #1 chk("R2", "comb copy", line_tx, 1'b1);
  endtask

  task automatic t_join;
    @(negedge clk) go_active = 1'b1;
    put_ones(5);
    put(1'b0, 1'b0, 1'b0);
    put_ones(6);
    chk("R3", "six ones not enough", on_loop, 1'b0);
    put_ones(1);
    chk("R4", "on_loop", on_loop, 1'b1);
    chk("R4", "brk_abort", brk_abort, 1'b1);
    chk("R4", "hunt", hunt, 1'b1);
    @(negedge clk) line_rx = 1'b0; #1 chk("R4", "delayed bit", line_tx, 1'b1);
  endtask

  task automatic t_flag;
    put(1'b0, 1'b0, 1'b0);
    chk("R5", "brk cleared by 0", brk_abort, 1'b0);
    chk("R4", "delayed zero", line_tx, 1'b0);
    put_ones(6);
    chk("R5", "hunt before flag end", hunt, 1'b1);
    put(1'b0, 1'b0, 1'b0);
    chk("R5", "hunt cleared by flag", hunt, 1'b0);
  endtask

  task automatic t_first_eop;
    put_ones(6);
    put_ones(1);
    chk("R6", "first eop repeated", line_tx, 1'b1);
    chk("R6", "no send on first eop", loop_sending, 1'b0);
  endtask

  task automatic t_eop_no_go;
    @(negedge clk) go_active = 1'b0;
    put(1'b0, 1'b0, 1'b0);
    put_ones(7);
    chk("R7", "no go eop repeated", line_tx, 1'b1);
    chk("R7", "no go no send", loop_sending, 1'b0);
  endtask

  task automatic t_send;
    logic [15:0] frame = 16'b0100_1101_0111_1110;
    @(negedge clk) go_active = 1'b1;
    put(1'b0, 1'b0, 1'b0);
    put_ones(6);
    chk("R7", "tx before conversion", line_tx, 1'b1);
    put_ones(1);
    chk("R7", "converted bit", line_tx, 1'b0);
    chk("R7", "loop_sending", loop_sending, 1'b1);
    chk("R7", "brk at send", brk_abort, 1'b1);
    chk("R7", "hunt at send", hunt, 1'b1);
    for (int i = 0; i < 16; i++) begin
      if (i == 5) begin
        @(negedge clk);
        go_active = 1'b0;
        loop_en = 1'b0;
      end
      put(~frame[i], frame[i], (i == 15));
      chk("R8", "local bit out", line_tx, frame[i]);
      if (i == 8) begin
        chk("R8", "sending after go drop", loop_sending, 1'b1);
        chk("R11", "still on loop", on_loop, 1'b1);
      end
    end
    chk("R9", "sending cleared", loop_sending, 1'b0);
    chk("R11", "on loop after frame", on_loop, 1'b1);
    put(1'b1, 1'b0, 1'b0);
    chk("R9", "delayed rx 1", line_tx, 1'b1);
    put(1'b0, 1'b1, 1'b0);
    chk("R9", "delayed rx 0", line_tx, 1'b0);
  endtask

  task automatic t_leave;
    put_ones(6);
    chk("R10", "stays inserted", on_loop, 1'b1);
    put_ones(1);
    chk("R10", "on_loop dropped", on_loop, 1'b0);
    chk("R10", "brk on drop", brk_abort, 1'b1);
    chk("R10", "hunt on drop", hunt, 1'b1);
    @(negedge clk) line_rx = 1'b0; #1 chk("R10", "comb copy after drop", line_tx, 1'b0);
  endtask

  task automatic t_reset_again;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "hunt after reset", hunt, 1'b0);
    chk("R1", "brk after reset", brk_abort, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_armed();
    t_join();
    t_flag();
    t_first_eop();
    t_eop_no_go();
    t_send();
    t_leave();
    t_reset_again();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule